// File: doc/BRIEF.md
# Escalating Watchdog Timer

This block is a watchdog that counts down a software-programmed period. Each time the count runs out before software has serviced it, the response becomes more severe. In the default escalating mode, consecutive unserviced expiries produce the following, in order:

1. a normal interrupt;
2. a fast interrupt;
3. a CPU reset pulse;
4. a full system reset pulse.

In the two-step legacy mode, the first expiry raises the interrupt. The second expiry pulses a reset that is meant for a chosen group of subunits only.

Software reaches the block through a simple write-only register port. The port holds four locations: the period, a control word, a kick address and an interrupt clear address. After each expiry the counter reloads itself, so the next stage can be reached without help from software. A kick, a control write or disabling the block restarts the count and drops the escalation back to the beginning. The two interrupts stay asserted until software clears them. The three reset outputs are pulses whose length in cycles software programs. The circuits that act on these resets lie outside the block.

Top module: `wdt_escalator`

## Requirements
- R1: After reset all five outputs are low and the watchdog is disabled, so no output rises however long the clock runs without a register write.
- R2: Once enabled with period value P (address 0), the counter expires every P+1 cycles. The first expiry in escalating mode sets irq_o on the edge that ends the (P+1)-th cycle after the enabling write.
- R3: In escalating mode, the second consecutive unserviced expiry sets fiq_o.
- R4: In escalating mode, the third consecutive expiry starts a cpu_rst_o pulse and the fourth starts a sys_rst_o pulse. Every further expiry repeats the sys_rst_o pulse.
- R5: Each reset pulse lasts exactly L cycles, where L is control bits [2+PW_W-1:2]. An L of 0 gives a one-cycle pulse.
- R6: irq_o and fiq_o stay high until a write to address 3. Data bit 0 of that write clears irq_o and data bit 1 clears fiq_o.
- R7: A write of any data to address 2 (kick) reloads the counter with the period and returns the escalation to its first stage.
- R8: Control bit 0 enables the watchdog. While it is clear, no output rises. Any write to the control word (address 1) reloads the counter and restarts escalation at the first stage.
- R9: A period written while the watchdog runs leaves the current countdown untouched and sets the length of every countdown after the next reload.
- R10: With control bit 1 set (legacy mode), the first expiry sets irq_o and the second starts a sub_rst_o pulse. Every later expiry repeats sub_rst_o, and fiq_o, cpu_rst_o and sys_rst_o never rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Register address: 0 period, 1 control, 2 kick, 3 interrupt clear |
| wr_data | input | DATA_W | Write data |
| irq_o | output | 1 | Sticky interrupt, first stage |
| fiq_o | output | 1 | Sticky fast interrupt, second escalating stage |
| cpu_rst_o | output | 1 | CPU reset pulse, third escalating stage |
| sys_rst_o | output | 1 | Full system reset pulse, fourth and later escalating stages |
| sub_rst_o | output | 1 | Subunit reset pulse, second and later legacy stages |

## Verification
The bench builds the block with an 8-bit counter, a 4-bit pulse-length field and a reset period value of 200. Periods of 3 to 7 cycles then take the escalation through all four stages, and one stage past saturation, within a few dozen cycles. A 300-cycle idle run after reset covers more than a full default period, which shows that nothing fires before the watchdog is enabled. With the short periods, a mid-countdown period change, and kicks spaced just inside the period, can each be checked on the exact edge where an output must or must not rise.

// File: rtl/wdt_esc_pkg.sv
// Package: shared register addresses and stage limits for the escalating
// watchdog. Assumes a 2-bit register address.
package wdt_esc_pkg;

    typedef enum logic [1:0] {
        WDT_A_PERIOD = 2'd0,
        WDT_A_CTRL   = 2'd1,
        WDT_A_KICK   = 2'd2,
        WDT_A_CLEAR  = 2'd3
    } wdt_addr_e;

    localparam int STAGE_W   = 3;
    localparam int ESC_LAST  = 4;
    localparam int LEG_LAST  = 2;
    localparam int N_PULSE   = 3;

    // Index of each reset pulse output in the fire vector
    localparam int P_CPU = 0;
    localparam int P_SYS = 1;
    localparam int P_SUB = 2;

endpackage

// File: rtl/wdt_esc_regs.sv
// Register file of the escalating watchdog.
// Holds the period, enable, legacy-mode bit and pulse length. Decodes kick
// and interrupt-clear writes into single-cycle strobes. A control write also
// counts as a restart (reload strobe). Assumes one write per cycle.
module wdt_esc_regs
    import wdt_esc_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          CNT_W      = 24,
    parameter int          PW_W       = 4,
    parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  period_q,
    output logic              en_q,
    output logic              legacy_q,
    output logic [PW_W-1:0]   plen_q,
    output logic              reload,
    output logic              clr_irq,
    output logic              clr_fiq
);

    localparam int PLEN_LSB = 2;

    wdt_addr_e addr;
    logic      wr_period;
    logic      wr_ctrl;
    logic      wr_kick;
    logic      wr_clear;

    // Decode the write address into per-register strobes
    always_comb begin
        addr      = wdt_addr_e'(wr_addr);
        wr_period = wr_en && (addr == WDT_A_PERIOD);
        wr_ctrl   = wr_en && (addr == WDT_A_CTRL);
        wr_kick   = wr_en && (addr == WDT_A_KICK);
        wr_clear  = wr_en && (addr == WDT_A_CLEAR);
        reload    = wr_kick || wr_ctrl;
        clr_irq   = wr_clear && wr_data[0];
        clr_fiq   = wr_clear && wr_data[1];
    end

    // Period register
    always_ff @(posedge clk) begin
        if (!rst_n)
            period_q <= PERIOD_RST;
        else if (wr_period)
            period_q <= wr_data[CNT_W-1:0];
    end

    // Control register: enable, mode and pulse length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            legacy_q <= 1'b0;
            plen_q   <= '0;
        end else if (wr_ctrl) begin
            en_q     <= wr_data[0];
            legacy_q <= wr_data[1];
            plen_q   <= wr_data[PLEN_LSB +: PW_W];
        end
    end

endmodule

// File: rtl/wdt_esc_counter.sv
// Down counter of the escalating watchdog.
// Counts from the period to zero. The zero cycle is the expiry cycle, after
// which the counter reloads itself. While disabled or on a reload strobe it
// holds the period, so the period only takes effect at a reload.
module wdt_esc_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             reload,
    input  logic [CNT_W-1:0] period,
    output logic             expire,
    output logic [CNT_W-1:0] cnt_q
);

    // Expiry: enabled, no restart this cycle, count exhausted
    always_comb begin
        expire = en && !reload && (cnt_q == '0);
    end

    // Count down, reloading on disable, restart or expiry
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en || reload || expire)
            cnt_q <= period;
        else
            cnt_q <= cnt_q - CNT_W'(1);
    end

endmodule

// File: rtl/wdt_esc_stage.sv
// Escalation stage tracker of the escalating watchdog.
// Counts consecutive expiries up to the last stage of the selected mode and
// saturates there. Turns each expiry into the action for its new stage:
// sticky interrupt flags or reset pulse triggers. A restart (kick, control
// write or disable) returns the stage to zero. A clear strobe drops a flag
// unless the same cycle sets it.
module wdt_esc_stage
    import wdt_esc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               expire,
    input  logic               restart,
    input  logic               legacy,
    input  logic               clr_irq,
    input  logic               clr_fiq,
    output logic               irq_q,
    output logic               fiq_q,
    output logic [N_PULSE-1:0] fire,
    output logic [STAGE_W-1:0] stage_q
);

    logic [STAGE_W-1:0] last;
    logic [STAGE_W-1:0] nxt;
    logic               set_irq;
    logic               set_fiq;

    // Work out the stage reached by this expiry and the action it brings
    always_comb begin
        last    = legacy ? STAGE_W'(LEG_LAST) : STAGE_W'(ESC_LAST);
        nxt     = (stage_q >= last) ? last : stage_q + STAGE_W'(1);
        set_irq = expire && (nxt == STAGE_W'(1));
        set_fiq = expire && !legacy && (nxt == STAGE_W'(2));
        fire    = '0;
        fire[P_CPU] = expire && !legacy && (nxt == STAGE_W'(3));
        fire[P_SYS] = expire && !legacy && (nxt == STAGE_W'(ESC_LAST));
        fire[P_SUB] = expire &&  legacy && (nxt == STAGE_W'(LEG_LAST));
    end

    // Stage counter: restart to zero, step on expiry
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else if (restart)
            stage_q <= '0;
        else if (expire)
            stage_q <= nxt;
    end

    // Sticky interrupt flags; setting wins over clearing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
        end else begin
            if (set_irq)
                irq_q <= 1'b1;
            else if (clr_irq)
                irq_q <= 1'b0;
            if (set_fiq)
                fiq_q <= 1'b1;
            else if (clr_fiq)
                fiq_q <= 1'b0;
        end
    end

endmodule

// File: rtl/wdt_esc_pulse.sv
// Reset pulse stretcher of the escalating watchdog.
// A fire strobe loads the programmed length (0 taken as 1). The output stays
// high while the remaining count is non-zero. A new strobe during a pulse
// restarts the full length.
module wdt_esc_pulse #(
    parameter int PW_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic [PW_W-1:0] len,
    output logic            pulse_o
);

    logic [PW_W-1:0] left_q;
    logic [PW_W-1:0] len_eff;

    // Length of zero still yields one cycle
    always_comb begin
        len_eff = (len == '0) ? PW_W'(1) : len;
        pulse_o = (left_q != '0);
    end

    // Remaining pulse cycles
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (fire)
            left_q <= len_eff;
        else if (left_q != '0)
            left_q <= left_q - PW_W'(1);
    end

endmodule

// File: rtl/wdt_escalator.sv
// Escalating watchdog timer, top level.
// Joins the register file, down counter, stage tracker and one pulse
// stretcher per reset output. Assumes a single clock domain and that the
// reset outputs are consumed by reset logic outside the block.
module wdt_escalator
    import wdt_esc_pkg::*;
#(
    parameter int               DATA_W     = 32,
    parameter int               CNT_W      = 24,
    parameter int               PW_W       = 4,
    parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              cpu_rst_o,
    output logic              sys_rst_o,
    output logic              sub_rst_o
);

    logic [CNT_W-1:0]   period_q;
    logic               en_q;
    logic               legacy_q;
    logic [PW_W-1:0]    plen_q;
    logic               reload;
    logic               clr_irq;
    logic               clr_fiq;
    logic               expire;
    logic [CNT_W-1:0]   cnt_q;
    logic [STAGE_W-1:0] stage_q;
    logic [N_PULSE-1:0] fire;
    logic [N_PULSE-1:0] pulse;
    logic               restart;

    wdt_esc_regs #(
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .PW_W      (PW_W),
        .PERIOD_RST(PERIOD_RST)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .period_q(period_q),
        .en_q    (en_q),
        .legacy_q(legacy_q),
        .plen_q  (plen_q),
        .reload  (reload),
        .clr_irq (clr_irq),
        .clr_fiq (clr_fiq)
    );

    wdt_esc_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_q),
        .reload(reload),
        .period(period_q),
        .expire(expire),
        .cnt_q (cnt_q)
    );

    // Escalation restarts on kick, control write or while disabled
    always_comb begin
        restart = reload || !en_q;
    end

    wdt_esc_stage u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire),
        .restart(restart),
        .legacy (legacy_q),
        .clr_irq(clr_irq),
        .clr_fiq(clr_fiq),
        .irq_q  (irq_o),
        .fiq_q  (fiq_o),
        .fire   (fire),
        .stage_q(stage_q)
    );

    for (genvar g = 0; g < N_PULSE; g++) begin : g_pulse
        wdt_esc_pulse #(
            .PW_W(PW_W)
        ) u_pulse (
            .clk    (clk),
            .rst_n  (rst_n),
            .fire   (fire[g]),
            .len    (plen_q),
            .pulse_o(pulse[g])
        );
    end

    // Map the pulse stretchers onto the reset outputs
    always_comb begin
        cpu_rst_o = pulse[P_CPU];
        sys_rst_o = pulse[P_SYS];
        sub_rst_o = pulse[P_SUB];
    end

endmodule

// File: rtl/wdt_escalator_chk.sv
// Assertion checker for the escalating watchdog, bound into wdt_escalator.
// Observes ports and the register, counter and stage state that separate
// submodules drive.
module wdt_escalator_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq_o,
    input logic              fiq_o,
    input logic              cpu_rst_o,
    input logic              sys_rst_o,
    input logic              en_q,
    input logic              legacy_q,
    input logic              reload,
    input logic [CNT_W-1:0]  period_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [2:0]        stage_q
);

    // R2: running counter steps down by one
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !reload && cnt_q != '0) |=> ((cnt_q + CNT_W'(1)) == $past(cnt_q)));

    // R7: restart loads the programmed period
    a_r7_reload_period: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && reload) |=> (cnt_q == $past(period_q)));

    // R8: nothing rises while disabled
    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !($rose(irq_o) || $rose(fiq_o) || $rose(cpu_rst_o) || $rose(sys_rst_o)));

    // R6: interrupt holds until cleared
    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(wr_en && wr_addr == 2'd3 && wr_data[0])) |=> irq_o);

    // R10: legacy mode never raises escalating-only outputs
    a_r10_legacy_no_fiq: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_q |=> !($rose(fiq_o) || $rose(cpu_rst_o) || $rose(sys_rst_o)));

    // R4 / R10: stage stays within the active mode's limit
    a_r4_stage_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q <= 3'd4) && (!legacy_q || stage_q <= 3'd2));

endmodule

bind wdt_escalator wdt_escalator_chk #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o),
    .cpu_rst_o(cpu_rst_o),
    .sys_rst_o(sys_rst_o),
    .en_q     (en_q),
    .legacy_q (legacy_q),
    .reload   (reload),
    .period_q (period_q),
    .cnt_q    (cnt_q),
    .stage_q  (stage_q)
);

// File: tb/wdt_escalator_tb.sv
// Directed bench for the escalating watchdog: one task per scenario.
module wdt_escalator_tb;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;
    localparam int PW_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic irq_o, fiq_o, cpu_rst_o, sys_rst_o, sub_rst_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    wdt_escalator #(
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .PW_W      (PW_W),
        .PERIOD_RST(8'd200)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .irq_o    (irq_o),
        .fiq_o    (fiq_o),
        .cpu_rst_o(cpu_rst_o),
        .sys_rst_o(sys_rst_o),
        .sub_rst_o(sub_rst_o)
    );

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // One write, issued at a negedge, taking effect on the next edge
    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [DATA_W-1:0] ctrl(input logic en, input logic leg, input logic [PW_W-1:0] len);
        ctrl = '0;
        ctrl[0] = en;
        ctrl[1] = leg;
        ctrl[2 +: PW_W] = len;
    endfunction

    task automatic setup(input logic [7:0] p);
        wr(2'd1, '0);
        wr(2'd3, 32'd3);
        wr(2'd0, {24'd0, p});
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(irq_o | fiq_o | cpu_rst_o | sys_rst_o | sub_rst_o, 1'b0, "R1", "outputs in reset");
        wt(2);
        rst_n = 1'b1;
        begin
            logic any = 1'b0;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                any |= irq_o | fiq_o | cpu_rst_o | sys_rst_o | sub_rst_o;
            end
            chk(any, 1'b0, "R1", "no output while idle");
        end
    endtask

    task automatic t_escalate();
        setup(8'd7);
        wr(2'd1, ctrl(1'b1, 1'b0, 4'd3));            // t=0
        wt(7); chk(irq_o, 1'b0, "R2", "irq before expiry");
        wt(1); chk(irq_o, 1'b1, "R2", "irq at first expiry");
        chk(fiq_o, 1'b0, "R3", "fiq after first expiry");
        wt(7); chk(fiq_o, 1'b0, "R3", "fiq before second expiry");
        wt(1); chk(fiq_o, 1'b1, "R3", "fiq at second expiry");
        wt(7); chk(cpu_rst_o, 1'b0, "R4", "cpu reset before third expiry");
        wt(1); chk(cpu_rst_o, 1'b1, "R4", "cpu reset at third expiry");
        wt(2); chk(cpu_rst_o, 1'b1, "R5", "cpu reset last pulse cycle");
        wt(1); chk(cpu_rst_o, 1'b0, "R5", "cpu reset after pulse");
        wt(4); chk(sys_rst_o, 1'b0, "R4", "sys reset before fourth expiry");
        wt(1); chk(sys_rst_o, 1'b1, "R4", "sys reset at fourth expiry");
        wt(7); chk(sys_rst_o, 1'b0, "R4", "sys reset gap");
        wt(1); chk(sys_rst_o, 1'b1, "R4", "sys reset repeats at fifth expiry");
        chk(cpu_rst_o, 1'b0, "R4", "cpu reset not repeated");
        chk(sub_rst_o, 1'b0, "R10", "no subunit reset in escalating mode");
        chk(irq_o, 1'b1, "R6", "irq still held");
        wr(2'd3, 32'd1);
        chk(irq_o, 1'b0, "R6", "irq cleared by bit 0");
        chk(fiq_o, 1'b1, "R6", "fiq kept when only bit 0 written");
        wr(2'd3, 32'd2);
        chk(fiq_o, 1'b0, "R6", "fiq cleared by bit 1");
    endtask

    task automatic t_kick();
        setup(8'd7);
        wr(2'd1, ctrl(1'b1, 1'b0, 4'd3));
        for (int i = 0; i < 5; i++) begin
            wt(5);
            wr(2'd2, '0);
        end
        chk(irq_o, 1'b0, "R7", "regular kicks prevent expiry");
        wt(7); chk(irq_o, 1'b0, "R7", "kick reloaded full period");
        wt(1); chk(irq_o, 1'b1, "R7", "expiry one period after last kick");
        wr(2'd2, 32'hDEAD);
        wt(8); chk(fiq_o, 1'b0, "R7", "kick returned escalation to stage one");
        chk(irq_o, 1'b1, "R7", "irq still set after kick");
        wt(8); chk(fiq_o, 1'b1, "R3", "fiq on second expiry after kick");
    endtask

    task automatic t_disable();
        wr(2'd1, ctrl(1'b0, 1'b0, 4'd3));
        wr(2'd3, 32'd3);
        begin
            logic any = 1'b0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                any |= irq_o | fiq_o | cpu_rst_o | sys_rst_o | sub_rst_o;
            end
            chk(any, 1'b0, "R8", "no output while disabled");
        end
        wr(2'd1, ctrl(1'b1, 1'b0, 4'd3));            // t=0
        wt(8);
        chk(irq_o, 1'b1, "R8", "irq on first expiry after re-enable");
        chk(fiq_o, 1'b0, "R8", "stage restarted by disable");
    endtask

    task automatic t_period();
        setup(8'd7);
        wr(2'd1, ctrl(1'b1, 1'b0, 4'd3));            // t=0
        wr(2'd0, 32'd3);                              // t=1
        wt(6); chk(irq_o, 1'b0, "R9", "old period still running");
        wt(1); chk(irq_o, 1'b1, "R9", "expiry on old period");
        wt(3); chk(fiq_o, 1'b0, "R9", "new period not yet done");
        wt(1); chk(fiq_o, 1'b1, "R9", "second expiry on new period");
    endtask

    task automatic t_legacy();
        setup(8'd5);
        wr(2'd1, ctrl(1'b1, 1'b1, 4'd2));            // t=0
        wt(5); chk(irq_o, 1'b0, "R10", "legacy irq before expiry");
        wt(1); chk(irq_o, 1'b1, "R10", "legacy irq at first expiry");
        wt(5); chk(sub_rst_o, 1'b0, "R10", "subunit reset before second expiry");
        wt(1); chk(sub_rst_o, 1'b1, "R10", "subunit reset at second expiry");
        chk(fiq_o | cpu_rst_o | sys_rst_o, 1'b0, "R10", "no escalating outputs");
        wt(1); chk(sub_rst_o, 1'b1, "R5", "subunit pulse second cycle");
        wt(1); chk(sub_rst_o, 1'b0, "R5", "subunit pulse ends after two");
        wt(4); chk(sub_rst_o, 1'b1, "R10", "subunit reset repeats");
        chk(fiq_o | cpu_rst_o | sys_rst_o, 1'b0, "R10", "still no escalating outputs");
    endtask

    task automatic t_zero_len();
        setup(8'd3);
        wr(2'd1, ctrl(1'b1, 1'b0, 4'd0));            // t=0
        wt(12); chk(cpu_rst_o, 1'b1, "R5", "zero length gives a pulse");
        wt(1);  chk(cpu_rst_o, 1'b0, "R5", "zero length pulse is one cycle");
    endtask

    initial begin
        t_reset();
        t_escalate();
        t_kick();
        t_disable();
        t_period();
        t_legacy();
        t_zero_len();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule